// File: doc/BRIEF.md
# Packed 64-bit Lane Adder

This block adds two vectors lane by lane. Each lane is 64 bits wide, and the default vector holds four lanes, so it is 256 bits wide. The adder works the same way for signed two's-complement and unsigned operands. It has no carry chain between lanes. When a lane sum overflows, the carry-out is dropped and the lane keeps only its low 64 bits. The block produces no flags.

A 3-bit operation code picks two things:
- how many lanes are summed;
- whether the destination bits above those lanes keep their old value or are cleared.

In the two-operand forms (codes 0 and 1), the old destination is the first addend. In the three-operand forms (codes 2 and 3), the first addend is `src_a`. Codes 4 to 7 are reserved. A reserved code returns the old destination unchanged and raises an illegal flag alongside the result.

Operands enter through a valid/ready input and results leave through a valid/ready output. A single register sits between the two. The rules for back-pressure are:
- `in_ready` is high whenever the output register is empty, or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, `out_data` and `out_illegal` hold their values.
- While `out_valid` is high and `out_ready` is low, no new input is accepted.

Top module: `lane_add_unit`

## Requirements
- R1: Lanes are added independently. A carry out of lane i never changes lane i+1. For example, all-ones plus one in every lane gives zero in every lane.
- R2: A lane sum is taken modulo 2^64. The carry-out is discarded.
- R3: Op code 0 (single lane): out[63:0] = dst_old[63:0] + src_b[63:0], and out[255:64] = dst_old[255:64].
- R4: Op code 1 (two lanes, keep upper): lanes 0 and 1 are dst_old + src_b, and out[255:128] = dst_old[255:128].
- R5: Op code 2 (two lanes, clear upper): lanes 0 and 1 are src_a + src_b, and out[255:128] = 0.
- R6: Op code 3 (four lanes): lanes 0 to 3 are src_a + src_b.
- R7: Op codes 4 to 7 are reserved. For these, out_illegal is 1 together with out_valid, and out_data = dst_old. For op codes 0 to 3, out_illegal is 0.
- R8: An input accepted on a clock edge (in_valid and in_ready both high) appears on out_data with out_valid high right after that same edge.
- R9: in_ready = !out_valid || out_ready. While out_valid is high and out_ready is low, out_valid, out_data and out_illegal hold steady.
- R10: A synchronous active-high reset clears out_valid, out_data and out_illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and op code are valid |
| in_ready | output | 1 | Block can accept operands |
| op_code | input | 3 | Operation: 0 to 3 legal, 4 to 7 reserved |
| dst_old | input | 256 | Current destination value |
| src_a | input | 256 | First addend for op codes 2 and 3 |
| src_b | input | 256 | Second addend for every op code |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 256 | Result vector |
| out_illegal | output | 1 | The result came from a reserved op code |

## Verification
Every result is due one clock edge after the edge that accepted its operands. The bench drives inputs on the falling edge. It lets one rising edge pass and then reads out_data, out_illegal and out_valid on the next falling edge, never earlier.

The stall test works differently. It holds out_ready low over two further rising edges and reads each time on a falling edge. The result must still be present and unchanged, and in_ready must be low. After out_ready is released, out_valid must drop one edge later.

// File: rtl/lane_add_pkg.sv
package lane_add_pkg;
  typedef enum logic [1:0] {
    OP_ONE_KEEP  = 2'd0,
    OP_PAIR_KEEP = 2'd1,
    OP_PAIR_ZERO = 2'd2,
    OP_QUAD      = 2'd3
  } lane_op_e;
endpackage

// File: rtl/lane_adder.sv
module lane_adder #(
  parameter int LANE_W = 64,
  parameter int LANES  = 4
) (
  input  logic [LANE_W*LANES-1:0] opnd_x,
  input  logic [LANE_W*LANES-1:0] opnd_y,
  output logic [LANE_W*LANES-1:0] lane_sum
);
  // one adder per lane; the carry-out is simply not kept
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_sum[g*LANE_W +: LANE_W] = opnd_x[g*LANE_W +: LANE_W] + opnd_y[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/lane_ctrl.sv
module lane_ctrl
  import lane_add_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [2:0]       op_code,
  output logic [LANES-1:0] take_sum,
  output logic [LANES-1:0] take_zero,
  output logic             reserved,
  output logic             first_is_a
);
  localparam int CW = $clog2(LANES + 1);
  localparam int PAIR = (LANES < 2) ? LANES : 2;

  lane_op_e  kind;
  logic [CW-1:0] active;

  assign kind       = lane_op_e'(op_code[1:0]);
  assign reserved   = op_code[2];
  assign first_is_a = op_code[1];

  always_comb begin
    unique case (kind)
      OP_ONE_KEEP:  active = CW'(1);
      OP_PAIR_KEEP: active = CW'(PAIR);
      OP_PAIR_ZERO: active = CW'(PAIR);
      default:      active = CW'(LANES);
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_sel
    assign take_sum[g]  = !reserved && (CW'(g) < active);
    assign take_zero[g] = !reserved && (kind == OP_PAIR_ZERO) && !(CW'(g) < active);
  end
endmodule

// File: rtl/lane_merge.sv
module lane_merge #(
  parameter int LANE_W = 64,
  parameter int LANES  = 4
) (
  input  logic [LANE_W*LANES-1:0] lane_sum,
  input  logic [LANE_W*LANES-1:0] dst_old,
  input  logic [LANES-1:0]        take_sum,
  input  logic [LANES-1:0]        take_zero,
  output logic [LANE_W*LANES-1:0] merged
);
  for (genvar g = 0; g < LANES; g++) begin : g_mux
    always_comb begin
      if (take_sum[g])       merged[g*LANE_W +: LANE_W] = lane_sum[g*LANE_W +: LANE_W];
      else if (take_zero[g]) merged[g*LANE_W +: LANE_W] = '0;
      else                   merged[g*LANE_W +: LANE_W] = dst_old[g*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/lane_add_unit.sv
module lane_add_unit #(
  parameter int LANE_W = 64,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [2:0]              op_code,
  input  logic [LANE_W*LANES-1:0] dst_old,
  input  logic [LANE_W*LANES-1:0] src_a,
  input  logic [LANE_W*LANES-1:0] src_b,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANE_W*LANES-1:0] out_data,
  output logic                    out_illegal
);
  localparam int VEC_W = LANE_W * LANES;

  logic [LANES-1:0] take_sum, take_zero;
  logic             reserved, first_is_a;
  logic [VEC_W-1:0] first_opnd, sums, merged;
  logic             accept;

  lane_ctrl #(.LANES(LANES)) u_ctrl (
    .op_code(op_code), .take_sum(take_sum), .take_zero(take_zero),
    .reserved(reserved), .first_is_a(first_is_a)
  );

  // two-operand forms add into the old destination
  assign first_opnd = first_is_a ? src_a : dst_old;

  lane_adder #(.LANE_W(LANE_W), .LANES(LANES)) u_add (
    .opnd_x(first_opnd), .opnd_y(src_b), .lane_sum(sums)
  );

  lane_merge #(.LANE_W(LANE_W), .LANES(LANES)) u_merge (
    .lane_sum(sums), .dst_old(dst_old), .take_sum(take_sum),
    .take_zero(take_zero), .merged(merged)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_illegal <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_data    <= merged;
      out_illegal <= reserved;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/lane_add_chk.sv
module lane_add_chk #(
  parameter int LANE_W = 64,
  parameter int LANES  = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [2:0]              op_code,
  input logic [LANE_W*LANES-1:0] dst_old,
  input logic [LANE_W*LANES-1:0] src_a,
  input logic [LANE_W*LANES-1:0] src_b,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [LANE_W*LANES-1:0] out_data,
  input logic                    out_illegal
);
  localparam int VEC_W = LANE_W * LANES;
  logic acc;
  assign acc = in_valid && in_ready;

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_illegal && out_data == '0));

  a_r8_valid_follows_accept: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid);

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_illegal)));

  a_r9_ready_rule: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (acc && op_code == 3'd2) |=> (out_data[VEC_W-1:2*LANE_W] == '0));

  a_r4_upper_kept: assert property (@(posedge clk) disable iff (rst)
    (acc && op_code == 3'd1) |=> (out_data[VEC_W-1:2*LANE_W] == $past(dst_old[VEC_W-1:2*LANE_W])));

  a_r6_low_lane_sum: assert property (@(posedge clk) disable iff (rst)
    (acc && op_code == 3'd3) |=> (out_data[LANE_W-1:0] == $past(src_a[LANE_W-1:0] + src_b[LANE_W-1:0])));

  a_r7_reserved_passthru: assert property (@(posedge clk) disable iff (rst)
    (acc && op_code[2]) |=> (out_illegal && out_data == $past(dst_old)));

  a_r7_legal_no_flag: assert property (@(posedge clk) disable iff (rst)
    (acc && !op_code[2]) |=> !out_illegal);
endmodule

bind lane_add_unit lane_add_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (.*);

// File: tb/test_lane_add_unit.sv
module test_lane_add_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [2:0]   op_code = '0;
  logic [255:0] dst_old = '0, src_a = '0, src_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [255:0] out_data;
  logic         out_illegal;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lane_add_unit i_lane_add_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op_code(op_code), .dst_old(dst_old), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_illegal(out_illegal)
  );

  function automatic logic [255:0] model(input logic [2:0] op, input logic [255:0] d,
                                         input logic [255:0] a, input logic [255:0] b);
    logic [255:0] r, x;
    int n;
    if (op[2]) return d;
    x = (op == 3'd2 || op == 3'd3) ? a : d;
    n = (op == 3'd0) ? 1 : (op == 3'd3) ? 4 : 2;
    for (int l = 0; l < 4; l++) begin
      logic [63:0] t;
      t = x[l*64 +: 64] + b[l*64 +: 64];
      if (l < n)           r[l*64 +: 64] = t;
      else if (op == 3'd2) r[l*64 +: 64] = '0;
      else                 r[l*64 +: 64] = d[l*64 +: 64];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [255:0] got, input logic [255:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [2:0] op, input logic [255:0] d,
                        input logic [255:0] a, input logic [255:0] b);
    @(negedge clk);
    op_code = op; dst_old = d; src_a = a; src_b = b; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " data"}, out_data, model(op, d, a, b));
    chk({req, " illegal"}, {255'd0, out_illegal}, {255'd0, op[2]});
    chk({req, " valid R8"}, {255'd0, out_valid}, 256'd1);
  endtask

  task automatic t_reset;  // R10
    chk("R10 valid", {255'd0, out_valid}, 256'd0);
    chk("R10 data", out_data, 256'd0);
    chk("R10 illegal", {255'd0, out_illegal}, 256'd0);
    chk("R10 ready", {255'd0, in_ready}, 256'd1);
  endtask

  task automatic t_no_leak;  // R1
    run_op("R1 all-ones+1", 3'd3, {4{64'h1234}}, {256{1'b1}}, {4{64'd1}});
    chk("R1 every lane zero", out_data, 256'd0);
    run_op("R1 lane0 carry only", 3'd3, '0, {192'd0, {64{1'b1}}}, {192'd0, 64'd1});
    chk("R1 lane1 untouched", {192'd0, out_data[127:64]}, 256'd0);
  endtask

  task automatic t_wrap;  // R2
    run_op("R2 wrap", 3'd3, '0, {4{64'h8000_0000_0000_0005}}, {4{64'h8000_0000_0000_0003}});
    chk("R2 low bits kept", out_data, {4{64'd8}});
  endtask

  task automatic t_modes;
    logic [255:0] d, a, b;
    d = {64'hDDDD_0003, 64'hDDDD_0002, 64'hDDDD_0001, 64'hFFFF_FFFF_FFFF_FFFE};
    a = {64'hAAAA_0003, 64'hAAAA_0002, 64'hAAAA_0001, 64'hAAAA_0000};
    b = {64'h1111_0003, 64'h1111_0002, 64'h1111_0001, 64'd5};
    run_op("R3 single lane", 3'd0, d, a, b);
    chk("R3 upper kept", {64'd0, out_data[255:64]}, {64'd0, d[255:64]});
    run_op("R4 pair keep", 3'd1, d, a, b);
    chk("R4 upper kept", {128'd0, out_data[255:128]}, {128'd0, d[255:128]});
    run_op("R5 pair zero", 3'd2, d, a, b);
    chk("R5 upper zero", {128'd0, out_data[255:128]}, 256'd0);
    run_op("R6 quad", 3'd3, d, a, b);
    chk("R6 lane3", {192'd0, out_data[255:192]}, {192'd0, 64'hBBBB_0006});
  endtask

  task automatic t_reserved;  // R7
    for (int k = 4; k < 8; k++)
      run_op("R7 reserved", 3'(k), {4{64'hC0DE}}, {4{64'h1}}, {4{64'h2}});
  endtask

  task automatic t_stall;  // R9
    logic [255:0] held;
    @(negedge clk);
    out_ready = 1'b0;
    op_code = 3'd3; dst_old = '0; src_a = {4{64'd7}}; src_b = {4{64'd9}}; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    held = out_data;
    chk("R9 first result", held, {4{64'd16}});
    src_a = {4{64'd100}};
    @(posedge clk);
    @(negedge clk);
    chk("R9 ready low", {255'd0, in_ready}, 256'd0);
    chk("R9 data held", out_data, held);
    chk("R9 valid held", {255'd0, out_valid}, 256'd1);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R9 drained", {255'd0, out_valid}, 256'd0);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_no_leak();
    t_wrap();
    t_modes();
    t_reserved();
    t_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule